// File: doc/BRIEF.md
# Iterative Radix-2 Integer Divider

This block computes 32-bit integer quotients and remainders for a processor's divide and modulo instructions. A one-cycle start strobe carries the operation code, the dividend and the divisor. The divider then works one quotient bit per clock, using shift-and-subtract on operand magnitudes. A single datapath covers four operations: unsigned quotient, unsigned remainder, signed quotient and signed remainder. For the signed operations the signs are removed before the loop and applied again after it.

A zero divisor does not enter the loop. The block finishes straight away with a result of zero and reports exception code 4. The surrounding pipeline holds the issuing instruction while busy is high. It takes the result on the done pulse and routes the exception code. The divider never changes condition flags.

Top module: `iter_divider`

## Requirements
- R1: Operation code 0x004 returns the unsigned quotient floor(dividend / divisor).
- R2: Operation code 0x005 returns the unsigned remainder dividend mod divisor.
- R3: Operation code 0x007 returns the two's-complement quotient, truncated toward zero.
- R4: Operation code 0x008 returns the two's-complement remainder. It carries the sign of the dividend and its magnitude is below the divisor's magnitude.
- R5: Signed division of 0x80000000 by 0xFFFFFFFF gives quotient 0x80000000 and remainder 0, with no exception.
- R6: For an accepted start with a non-zero divisor, busy is high for exactly the 32 cycles after the start edge. Done is high in the first cycle after busy falls. The result is valid from that cycle and holds until the next completion.
- R7: Done is high for one cycle per completion.
- R8: For an accepted start with a zero divisor, done is high in the cycle right after the start edge and busy stays low. The result is 0, the divide-by-zero flag is 1 and the exception code is 4.
- R9: A completion with a non-zero divisor leaves the divide-by-zero flag at 0 and the exception code at 0.
- R10: A start strobe while busy is high is ignored. The running operation keeps its operands, its result and its completion cycle.
- R11: A start strobe whose code is not one of 0x004, 0x005, 0x007 and 0x008 is ignored. Neither busy nor done rises.
- R12: After reset, busy, done, the result, the flag and the exception code are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request strobe, sampled when busy is low |
| opcode | input | 10 | Operation code (0x004, 0x005, 0x007, 0x008) |
| dividend | input | 32 | Dividend operand |
| divisor | input | 32 | Divisor operand |
| busy | output | 1 | Iteration in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Quotient or remainder |
| divByZero | output | 1 | Last completion had a zero divisor |
| excCode | output | 4 | 4 when divByZero is set, otherwise 0 |

## Verification
Mixed-sign operand pairs are used to check truncation toward zero and the remainder's sign. A design that rounds by flooring, or that gives the remainder the divisor's sign, returns -4 or +1 where -3 and -1 are due. The most negative value divided by -1 is checked for a saturated or trapping result, and the same bit pattern is run through the unsigned codes to show that signedness follows the code. Other checks cover a zero divisor (it must finish at once and must not spin 32 cycles), a zero-divisor start arriving mid-operation (it must neither restart nor truncate the run), and an unrecognised code with a zero divisor (it must not raise the exception).

// File: rtl/div_pkg.sv
package div_pkg;

  localparam int OP_W = 10;

  localparam logic [OP_W-1:0] OP_UQUO = 10'h004;
  localparam logic [OP_W-1:0] OP_UREM = 10'h005;
  localparam logic [OP_W-1:0] OP_SQUO = 10'h007;
  localparam logic [OP_W-1:0] OP_SREM = 10'h008;

  localparam logic [3:0] EXC_DIV_ZERO = 4'd4;

  typedef enum logic [1:0] {
    MODE_UQUO = 2'd0,
    MODE_UREM = 2'd1,
    MODE_SQUO = 2'd2,
    MODE_SREM = 2'd3
  } divMode_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;      // capture operands, begin iterating
    logic step;      // perform one shift-subtract step
    logic last;      // this step is the final one
    logic zeroDone;  // zero divisor: finish immediately
  } divStrobe_t;

  function automatic logic isDivOp(input logic [OP_W-1:0] op);
    return (op == OP_UQUO) || (op == OP_UREM) || (op == OP_SQUO) || (op == OP_SREM);
  endfunction

  function automatic divMode_t modeOf(input logic [OP_W-1:0] op);
    case (op)
      OP_UREM: return MODE_UREM;
      OP_SQUO: return MODE_SQUO;
      OP_SREM: return MODE_SREM;
      default: return MODE_UQUO;
    endcase
  endfunction

endpackage

// File: rtl/div_ctrl.sv
module div_ctrl
  import div_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       opValid,
  input  logic       divisorZero,
  output divStrobe_t strobe,
  output logic       busy,
  output logic       done
);

  localparam int CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WIDTH - 1);

  logic             busyQ;
  logic             doneQ;
  logic [CNT_W-1:0] cnt;
  logic             accept;

  assign accept = start && opValid && !busyQ;

  always_comb begin
    strobe.load     = accept && !divisorZero;
    strobe.zeroDone = accept && divisorZero;
    strobe.step     = busyQ;
    strobe.last     = busyQ && (cnt == LAST_CNT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      doneQ <= 1'b0;
      cnt   <= '0;
    end else begin
      doneQ <= strobe.zeroDone || strobe.last;
      if (strobe.load) begin
        busyQ <= 1'b1;
        cnt   <= '0;
      end else if (strobe.last) begin
        busyQ <= 1'b0;
      end else if (busyQ) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign busy = busyQ;
  assign done = doneQ;

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ);

  // R6
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busyQ && doneQ));

  // R6
  busy_fall_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyQ) |-> doneQ);

  // R6
  busy_rise_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyQ) |-> (cnt == '0));

  // R10
  ignored_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && start && (cnt != LAST_CNT)) |=> (busyQ && (cnt == $past(cnt) + 1'b1)));

endmodule

// File: rtl/div_datapath.sv
module div_datapath
  import div_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  divStrobe_t        strobe,
  input  logic [OP_W-1:0]   opcode,
  input  logic [WIDTH-1:0]  dividend,
  input  logic [WIDTH-1:0]  divisor,
  output logic              divisorZero,
  output logic [WIDTH-1:0]  result,
  output logic              divByZero
);

  logic [WIDTH-1:0] remQ, quoQ, dvsQ, resultQ;
  logic             negQuoQ, negRemQ, dzQ;
  divMode_t         modeQ;

  // Operand conditioning
  divMode_t         inMode;
  logic             inSigned, aNeg, bNeg;
  logic [WIDTH-1:0] aMag, bMag;

  always_comb begin
    inMode   = modeOf(opcode);
    inSigned = (inMode == MODE_SQUO) || (inMode == MODE_SREM);
    aNeg     = inSigned && dividend[WIDTH-1];
    bNeg     = inSigned && divisor[WIDTH-1];
    aMag     = aNeg ? ('0 - dividend) : dividend;
    bMag     = bNeg ? ('0 - divisor)  : divisor;
  end

  assign divisorZero = (divisor == '0);

  // One restoring step
  logic [WIDTH:0]   shifted, diff;
  logic             fits;
  logic [WIDTH-1:0] nextRem, nextQuo, fixQuo, fixRem, finalVal;

  always_comb begin
    shifted  = {remQ, quoQ[WIDTH-1]};
    diff     = shifted - {1'b0, dvsQ};
    fits     = !diff[WIDTH];
    nextRem  = fits ? diff[WIDTH-1:0] : shifted[WIDTH-1:0];
    nextQuo  = {quoQ[WIDTH-2:0], fits};
    fixQuo   = negQuoQ ? ('0 - nextQuo) : nextQuo;
    fixRem   = negRemQ ? ('0 - nextRem) : nextRem;
    finalVal = ((modeQ == MODE_UQUO) || (modeQ == MODE_SQUO)) ? fixQuo : fixRem;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remQ    <= '0;
      quoQ    <= '0;
      dvsQ    <= '0;
      resultQ <= '0;
      negQuoQ <= 1'b0;
      negRemQ <= 1'b0;
      dzQ     <= 1'b0;
      modeQ   <= MODE_UQUO;
    end else if (strobe.load) begin
      remQ    <= '0;
      quoQ    <= aMag;
      dvsQ    <= bMag;
      modeQ   <= inMode;
      negQuoQ <= aNeg ^ bNeg;
      negRemQ <= aNeg;
      dzQ     <= 1'b0;
    end else if (strobe.zeroDone) begin
      resultQ <= '0;
      dzQ     <= 1'b1;
    end else if (strobe.step) begin
      remQ <= nextRem;
      quoQ <= nextQuo;
      if (strobe.last) resultQ <= finalVal;
    end
  end

  assign result    = resultQ;
  assign divByZero = dzQ;

  // R2
  rem_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |-> (remQ < dvsQ));

  // R8
  zero_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.zeroDone |=> (resultQ == '0) && dzQ);

  // R9
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> !dzQ);

endmodule

// File: rtl/iter_divider.sv
module iter_divider
  import div_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [OP_W-1:0]   opcode,
  input  logic [WIDTH-1:0]  dividend,
  input  logic [WIDTH-1:0]  divisor,
  output logic              busy,
  output logic              done,
  output logic [WIDTH-1:0]  result,
  output logic              divByZero,
  output logic [3:0]        excCode
);

  divStrobe_t strobe;
  logic       divisorZero;
  logic       opValid;

  assign opValid = isDivOp(opcode);

  div_ctrl #(.WIDTH(WIDTH)) ctrlInst (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .opValid     (opValid),
    .divisorZero (divisorZero),
    .strobe      (strobe),
    .busy        (busy),
    .done        (done)
  );

  div_datapath #(.WIDTH(WIDTH)) dpInst (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .opcode      (opcode),
    .dividend    (dividend),
    .divisor     (divisor),
    .divisorZero (divisorZero),
    .result      (result),
    .divByZero   (divByZero)
  );

  assign excCode = divByZero ? EXC_DIV_ZERO : 4'd0;

  // R8
  zero_divisor_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && isDivOp(opcode) && (divisor == '0))
      |=> (done && !busy && (result == '0) && (excCode == EXC_DIV_ZERO)));

  // R11
  bad_op_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && !isDivOp(opcode)) |=> (!busy && !done));

endmodule

// File: tb/iter_divider_test.sv
module iter_divider_test;
  import div_pkg::*;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [9:0]  opcode = '0;
  logic [31:0] dividend = '0;
  logic [31:0] divisor = '0;
  logic        busy, done, divByZero;
  logic [31:0] result;
  logic [3:0]  excCode;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  iter_divider uut (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode),
    .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
    .result(result), .divByZero(divByZero), .excCode(excCode)
  );

  // {tag, opcode, dividend, divisor, expected}
  localparam int NV = 17;
  localparam logic [109:0] VECS [NV] = '{
    {4'd1, OP_UQUO, 32'd100,        32'd7,          32'd14},
    {4'd2, OP_UREM, 32'd100,        32'd7,          32'd2},
    {4'd1, OP_UQUO, 32'hFFFFFFFF,   32'd1,          32'hFFFFFFFF},
    {4'd1, OP_UQUO, 32'hFFFFFFFF,   32'h10,         32'h0FFFFFFF},
    {4'd2, OP_UREM, 32'hFFFFFFFF,   32'h10,         32'h0000000F},
    {4'd1, OP_UQUO, 32'd5,          32'd9,          32'd0},
    {4'd2, OP_UREM, 32'd5,          32'd9,          32'd5},
    {4'd3, OP_SQUO, 32'hFFFFFFF9,   32'd2,          32'hFFFFFFFD},
    {4'd4, OP_SREM, 32'hFFFFFFF9,   32'd2,          32'hFFFFFFFF},
    {4'd3, OP_SQUO, 32'd7,          32'hFFFFFFFE,   32'hFFFFFFFD},
    {4'd4, OP_SREM, 32'd7,          32'hFFFFFFFE,   32'd1},
    {4'd3, OP_SQUO, 32'hFFFFFFF9,   32'hFFFFFFFE,   32'd3},
    {4'd4, OP_SREM, 32'hFFFFFFF9,   32'hFFFFFFFE,   32'hFFFFFFFF},
    {4'd5, OP_SQUO, 32'h80000000,   32'hFFFFFFFF,   32'h80000000},
    {4'd5, OP_SREM, 32'h80000000,   32'hFFFFFFFF,   32'd0},
    {4'd1, OP_UQUO, 32'h80000000,   32'hFFFFFFFF,   32'd0},
    {4'd3, OP_SQUO, 32'd1000,       32'd10,         32'd100}
  };

  function automatic string tagOf(input logic [3:0] t);
    case (t)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [9:0] op, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    start = 1'b1; opcode = op; dividend = a; divisor = b;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic runFull(input string req, input logic [9:0] op,
                         input logic [31:0] a, input logic [31:0] b, input logic [31:0] exp);
    bit ok;
    issue(op, a, b);
    ok = busy && !done;
    for (int n = 1; n <= 31; n++) begin
      @(negedge clk);
      if (!busy || done) ok = 1'b0;
    end
    @(negedge clk);
    check(ok && done && !busy, "R6", "busy for 32 cycles then done", {31'd0, done}, 32'd1);
    check(result == exp, req, "result", result, exp);
    check(!divByZero && excCode == 4'd0, "R9", "no exception", {28'd0, excCode}, 32'd0);
    @(negedge clk);
    check(!done, "R7", "done single cycle", {31'd0, done}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    bit ok;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R12
    check(!busy && !done && result == '0 && !divByZero && excCode == 4'd0,
          "R12", "reset state", result, 32'd0);

    // R8 zero divisor, unsigned quotient
    issue(OP_UQUO, 32'd123, 32'd0);
    check(done && !busy, "R8", "immediate completion", {30'd0, busy, done}, 32'd1);
    check(result == 32'd0, "R8", "zero result", result, 32'd0);
    check(divByZero && excCode == 4'd4, "R8", "exception code", {28'd0, excCode}, 32'd4);
    @(negedge clk);
    check(!done, "R7", "done single cycle after zero divisor", {31'd0, done}, 32'd0);

    // R8 zero divisor, signed remainder
    issue(OP_SREM, 32'hFFFFFF00, 32'd0);
    check(done && result == 32'd0 && excCode == 4'd4, "R8", "signed zero divisor",
          result, 32'd0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      runFull(tagOf(VECS[i][109:106]), VECS[i][105:96], VECS[i][95:64],
              VECS[i][63:32], VECS[i][31:0]);
    end

    // R10 start during busy carries a zero divisor and a new code
    issue(OP_UQUO, 32'd100, 32'd7);
    ok = busy && !done;
    for (int n = 1; n <= 31; n++) begin
      if (n == 10) begin
        start = 1'b1; opcode = OP_UREM; dividend = 32'd9; divisor = 32'd0;
      end
      @(negedge clk);
      start = 1'b0;
      if (!busy || done) ok = 1'b0;
    end
    @(negedge clk);
    check(ok && done, "R10", "completion time unchanged", {31'd0, done}, 32'd1);
    check(result == 32'd14, "R10", "result unchanged", result, 32'd14);
    check(!divByZero, "R10", "no exception from ignored start", {31'd0, divByZero}, 32'd0);
    repeat (3) @(negedge clk);
    check(result == 32'd14, "R6", "result held after done", result, 32'd14);

    // R11 unrecognised code with zero divisor
    issue(10'h006, 32'd50, 32'd0);
    ok = !busy && !done;
    repeat (3) begin
      @(negedge clk);
      if (busy || done) ok = 1'b0;
    end
    check(ok, "R11", "no busy or done", {30'd0, busy, done}, 32'd0);
    check(!divByZero && result == 32'd14, "R11", "state untouched", result, 32'd14);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule